// File: doc/BRIEF.md
# Status Register Read Sequencer

This block sits in a memory controller and carries out a status-register read on a mobile DDR device. A requester raises `req_i`. The sequencer takes the request and waits until the rest of the controller reports that no reads or writes are still in flight. If any bank is open, it closes all banks with a precharge-all and waits out the row precharge time. It then issues a mode-set command with the bank address steered to the status-register slot. After the status-read setup gap, it issues a read. It collects the two data words of the fixed burst of two after the CAS latency. It signals completion once the recovery gap after the read has passed.

The flow is a single state machine:

- IDLE goes to DRAIN when a request is accepted.
- DRAIN goes to PREALL if banks are open, or to STATREQ if all banks are closed. It does so once traffic is idle.
- PREALL goes to WAIT_RP, and WAIT_RP goes to STATREQ.
- STATREQ goes to WAIT_SRR, and WAIT_SRR goes to READ.
- READ goes to WAIT_SRC, and WAIT_SRC goes to DONE.
- DONE goes back to IDLE.

The precharge time, the setup gap, the recovery gap and the CAS latency are parameters given in clock cycles. Any gap below 2 is raised to 2. The recovery gap is also stretched to at least CAS latency + 2, so that both words are held before completion.

Top module: `srr_seq`

## Requirements
- R1: `cmd_o` encodes 0 = NOP, 1 = precharge-all, 2 = mode-set, 3 = read. The status-register command is a mode-set with `ba_o` = 2'b01 and `addr_o` all zeros.
- R2: A request is taken only while the sequencer is idle. `ack_o` is high in that same cycle and `busy_o` is high from the next cycle. A request raised while busy, including during the done cycle, is ignored: `ack_o` stays low and no extra sequence starts.
- R3: No command is issued while `traffic_idle_i` is low in DRAIN. The first command comes in the cycle after the DRAIN cycle in which `traffic_idle_i` is seen high.
- R4: If `banks_open_i` is high when the drain ends, a precharge-all is issued first and the mode-set follows exactly T_RP cycles later. Otherwise the mode-set is the first command and no precharge-all is issued.
- R5: The read is issued exactly T_SRR cycles after the mode-set, with `ba_o` = 0 and `addr_o` = 0. Exactly one mode-set and one read are issued per sequence.
- R6: The data word present CAS_LAT cycles after the read goes to `result_o[DQ_W-1:0]`. The word present one cycle later goes to `result_o[2*DQ_W-1:DQ_W]`. The result holds until the next capture.
- R7: `done_o` pulses for one cycle, max(T_SRC, CAS_LAT+2) cycles after the read. Only NOP is issued between the read and done. `busy_o` falls in the cycle after `done_o`.
- R8: After reset, `cmd_o` is NOP and `busy_o`, `done_o` and `result_o` are 0.
- R9: While not busy, `cmd_o` is NOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Request a status-register read |
| ack_o | output | 1 | Request accepted this cycle |
| busy_o | output | 1 | Sequence in progress |
| traffic_idle_i | input | 1 | No reads or writes outstanding |
| banks_open_i | input | 1 | At least one bank is open |
| cmd_o | output | 2 | Command code (see R1) |
| ba_o | output | 2 | Bank address |
| addr_o | output | ADDR_W | Address bus |
| dq_i | input | DQ_W | Read data from the device |
| result_o | output | 2*DQ_W | Captured status words {second, first} |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The done cycle and a fresh request can land in the same cycle. A correct design must not accept the request there, but must accept it one cycle later in IDLE. The bench provokes this by holding `req_i` high for a whole sequence. It judges the result by checking that `ack_o` is low in the done cycle and high in the following idle cycle. It then drops the request before the edge and confirms that no second sequence begins. Requests poked in the middle of a sequence are judged the same way, by the count of mode-set and read commands.

// File: rtl/srr_pkg.sv
package srr_pkg;

    typedef enum logic [1:0] {
        CMD_NOP     = 2'd0,
        CMD_PREALL  = 2'd1,
        CMD_MODESET = 2'd2,
        CMD_READ    = 2'd3
    } mem_cmd_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DRAIN,
        ST_PREALL,
        ST_WAIT_RP,
        ST_STATREQ,
        ST_WAIT_SRR,
        ST_READ,
        ST_WAIT_SRC,
        ST_DONE
    } seq_state_e;

    localparam logic [1:0] BA_STATUS = 2'b01;

endpackage

// File: rtl/srr_wait_ctr.sv
module srr_wait_ctr #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         last
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign last = (cnt == W'(1));
endmodule

// File: rtl/srr_capture.sv
module srr_capture #(
    parameter int DW  = 16,
    parameter int LAT = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [DW-1:0] dq,
    output logic [2*DW-1:0] words
);
    localparam int CW = $clog2(LAT + 2) + 1;

    logic          active;
    logic [CW-1:0] cnt;
    logic [DW-1:0] first_q, second_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active   <= 1'b0;
            cnt      <= '0;
            first_q  <= '0;
            second_q <= '0;
        end else if (start) begin
            active <= 1'b1;
            cnt    <= CW'(1);
        end else if (active) begin
            cnt <= cnt + 1'b1;
            if (cnt == CW'(LAT))
                first_q <= dq;
            if (cnt == CW'(LAT + 1)) begin
                second_q <= dq;
                active   <= 1'b0;
            end
        end
    end

    assign words = {second_q, first_q};
endmodule

// File: rtl/srr_seq.sv
module srr_seq
    import srr_pkg::*;
#(
    parameter int DQ_W    = 16,
    parameter int ADDR_W  = 13,
    parameter int CAS_LAT = 3,
    parameter int T_RP    = 3,
    parameter int T_SRR   = 4,
    parameter int T_SRC   = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_i,
    output logic                ack_o,
    output logic                busy_o,
    input  logic                traffic_idle_i,
    input  logic                banks_open_i,
    output logic [1:0]          cmd_o,
    output logic [1:0]          ba_o,
    output logic [ADDR_W-1:0]   addr_o,
    input  logic [DQ_W-1:0]     dq_i,
    output logic [2*DQ_W-1:0]   result_o,
    output logic                done_o
);
    localparam int RP_C   = (T_RP  < 2) ? 2 : T_RP;
    localparam int SRR_C  = (T_SRR < 2) ? 2 : T_SRR;
    localparam int SRC_C  = (T_SRC < 2) ? 2 : T_SRC;
    localparam int REC_C  = (SRC_C > CAS_LAT + 2) ? SRC_C : CAS_LAT + 2;
    localparam int MAX_A  = (RP_C > SRR_C) ? RP_C : SRR_C;
    localparam int MAX_G  = (MAX_A > REC_C) ? MAX_A : REC_C;
    localparam int CNT_W  = $clog2(MAX_G + 1);

    seq_state_e state, state_nx;
    logic             ctr_load, ctr_last;
    logic [CNT_W-1:0] ctr_val;

    srr_wait_ctr #(.W(CNT_W)) u_wait (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ctr_load),
        .load_val (ctr_val),
        .last     (ctr_last)
    );

    srr_capture #(.DW(DQ_W), .LAT(CAS_LAT)) u_cap (
        .clk   (clk),
        .rst_n (rst_n),
        .start (state == ST_READ),
        .dq    (dq_i),
        .words (result_o)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:     if (req_i) state_nx = ST_DRAIN;
            ST_DRAIN:    if (traffic_idle_i)
                             state_nx = banks_open_i ? ST_PREALL : ST_STATREQ;
            ST_PREALL:   state_nx = ST_WAIT_RP;
            ST_WAIT_RP:  if (ctr_last) state_nx = ST_STATREQ;
            ST_STATREQ:  state_nx = ST_WAIT_SRR;
            ST_WAIT_SRR: if (ctr_last) state_nx = ST_READ;
            ST_READ:     state_nx = ST_WAIT_SRC;
            ST_WAIT_SRC: if (ctr_last) state_nx = ST_DONE;
            ST_DONE:     state_nx = ST_IDLE;
            default:     state_nx = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        cmd_o    = CMD_NOP;
        ba_o     = 2'b00;
        addr_o   = '0;
        done_o   = 1'b0;
        ctr_load = 1'b0;
        ctr_val  = '0;
        unique case (state)
            ST_PREALL: begin
                cmd_o    = CMD_PREALL;
                ctr_load = 1'b1;
                ctr_val  = CNT_W'(RP_C - 1);
            end
            ST_STATREQ: begin
                cmd_o    = CMD_MODESET;
                ba_o     = BA_STATUS;
                ctr_load = 1'b1;
                ctr_val  = CNT_W'(SRR_C - 1);
            end
            ST_READ: begin
                cmd_o    = CMD_READ;
                ctr_load = 1'b1;
                ctr_val  = CNT_W'(REC_C - 1);
            end
            ST_DONE: done_o = 1'b1;
            default: ;
        endcase
    end

    assign ack_o  = (state == ST_IDLE) && req_i;
    assign busy_o = (state != ST_IDLE);
endmodule

// File: rtl/srr_seq_chk.sv
module srr_seq_chk #(
    parameter int ADDR_W  = 13,
    parameter int CAS_LAT = 3,
    parameter int T_SRR   = 4,
    parameter int T_SRC   = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ack_o,
    input logic              busy_o,
    input logic              done_o,
    input logic [1:0]        cmd_o,
    input logic [1:0]        ba_o,
    input logic [ADDR_W-1:0] addr_o
);
    localparam int SRR_C = (T_SRR < 2) ? 2 : T_SRR;
    localparam int SRC_C = (T_SRC < 2) ? 2 : T_SRC;
    localparam int REC_C = (SRC_C > CAS_LAT + 2) ? SRC_C : CAS_LAT + 2;

    logic [15:0] since_ms, since_rd;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_ms <= '0;
            since_rd <= '0;
        end else begin
            if (cmd_o == 2'd2)             since_ms <= 16'd1;
            else if (since_ms != '0 && since_ms != '1) since_ms <= since_ms + 1'b1;
            if (cmd_o == 2'd3)             since_rd <= 16'd1;
            else if (since_rd != '0 && since_rd != '1) since_rd <= since_rd + 1'b1;
        end
    end

    a_r1_status_cmd_enc: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == 2'd2) |-> (ba_o == 2'b01 && addr_o == '0));

    a_r5_read_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == 2'd3) |-> (ba_o == 2'b00 && addr_o == '0 && since_ms == 16'(SRR_C)));

    a_r7_done_gap: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (since_rd == 16'(REC_C)));

    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !busy_o));

    a_r2_ack_idle: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> !busy_o);

    a_r2_busy_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |=> busy_o);

    a_r9_idle_nop: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (cmd_o == 2'd0));
endmodule

bind srr_seq srr_seq_chk #(
    .ADDR_W  (ADDR_W),
    .CAS_LAT (CAS_LAT),
    .T_SRR   (T_SRR),
    .T_SRC   (T_SRC)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .ack_o  (ack_o),
    .busy_o (busy_o),
    .done_o (done_o),
    .cmd_o  (cmd_o),
    .ba_o   (ba_o),
    .addr_o (addr_o)
);

// File: tb/srr_seq_tb.sv
module srr_seq_tb;
    localparam int DQ_W = 16, ADDR_W = 13, CL = 3, TRP = 3, TSRR = 4, TSRC = 6;
    localparam int REC = (TSRC > CL + 2) ? TSRC : CL + 2;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_i = 1'b0, traffic_idle_i = 1'b0, banks_open_i = 1'b0;
    logic [DQ_W-1:0] dq_i = '0;
    logic ack_o, busy_o, done_o;
    logic [1:0] cmd_o, ba_o;
    logic [ADDR_W-1:0] addr_o;
    logic [2*DQ_W-1:0] result_o;

    int nchk = 0, nerr = 0;
    int cyc = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    srr_seq #(.DQ_W(DQ_W), .ADDR_W(ADDR_W), .CAS_LAT(CL), .T_RP(TRP),
              .T_SRR(TSRR), .T_SRC(TSRC)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .ack_o(ack_o), .busy_o(busy_o),
        .traffic_idle_i(traffic_idle_i), .banks_open_i(banks_open_i),
        .cmd_o(cmd_o), .ba_o(ba_o), .addr_o(addr_o), .dq_i(dq_i),
        .result_o(result_o), .done_o(done_o)
    );

    // {banks_open[31], drain_delay[30:24], poke_step[23:16], seed[15:0]}
    localparam logic [31:0] VEC [4] = '{
        {1'b1, 7'd1, 8'd0, 16'hA5C3},
        {1'b0, 7'd3, 8'd3, 16'h1234},
        {1'b1, 7'd4, 8'd9, 16'hBEEF},
        {1'b0, 7'd1, 8'd0, 16'h0F0F}
    };

    function automatic logic [DQ_W-1:0] pat(input int c, input logic [15:0] seed);
        return DQ_W'(seed ^ DQ_W'(c * 32'h1357));
    endfunction

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run_seq(input bit bo, input int d, input int poke,
                           input logic [15:0] seed, input bit hold);
        int t_req, t_pre, t_ms, t_rd, t_done, t_first, n_pre, n_ms, n_rd;
        bit enc_ok, ack_busy;
        logic [2*DQ_W-1:0] res;
        t_pre = -1; t_ms = -1; t_rd = -1; t_done = -1; t_first = -1;
        n_pre = 0; n_ms = 0; n_rd = 0; enc_ok = 1'b1; ack_busy = 1'b0; res = '0;
        banks_open_i = bo; traffic_idle_i = 1'b0; req_i = 1'b1; t_req = cyc;
        #1;
        chk(ack_o == 1'b1, "R2 ack in idle", ack_o, 1);
        for (int n = 1; n <= 80; n++) begin
            @(negedge clk);
            if (n == 1) begin
                chk(busy_o == 1'b1, "R2 busy after ack", busy_o, 1);
                if (!hold) req_i = 1'b0;
            end
            if (ack_o && busy_o) ack_busy = 1'b1;
            if (cmd_o != 2'd0 && t_first < 0) t_first = cyc;
            if (cmd_o == 2'd1) begin n_pre++; t_pre = cyc; end
            if (cmd_o == 2'd2) begin
                n_ms++; t_ms = cyc;
                if (ba_o != 2'b01 || addr_o != '0) enc_ok = 1'b0;
            end
            if (cmd_o == 2'd3) begin
                n_rd++; t_rd = cyc;
                if (ba_o != 2'b00 || addr_o != '0) enc_ok = 1'b0;
            end
            if (cmd_o != 2'd0 && t_rd >= 0 && cyc > t_rd) enc_ok = 1'b0;
            if (done_o) begin
                t_done = cyc; res = result_o;
                if (hold) chk(ack_o == 1'b0, "R2 no ack in done cycle", ack_o, 0);
                break;
            end
            dq_i = pat(cyc, seed);
            if (cyc == t_req + d) traffic_idle_i = 1'b1;
            if (poke != 0 && n == poke) req_i = 1'b1;
            else if (poke != 0 && n == poke + 1 && !hold) req_i = 1'b0;
        end
        chk(t_first == t_req + d + 1, "R3 first command after drain", t_first, t_req + d + 1);
        if (bo) begin
            chk(n_pre == 1 && t_pre == t_first, "R4 precharge-all first", t_pre, t_first);
            chk(t_ms == t_pre + TRP, "R4 mode-set after tRP", t_ms, t_pre + TRP);
        end else begin
            chk(n_pre == 0 && t_ms == t_first, "R4 no precharge when closed", n_pre, 0);
        end
        chk(enc_ok, "R1 command encoding", enc_ok, 1);
        chk(t_rd == t_ms + TSRR, "R5 read after tSRR", t_rd, t_ms + TSRR);
        chk(n_ms == 1 && n_rd == 1, "R5 one mode-set one read", {n_ms, n_rd}, {32'd1, 32'd1});
        chk(!ack_busy, "R2 request while busy ignored", ack_busy, 0);
        chk(res == {pat(t_rd + CL + 1, seed), pat(t_rd + CL, seed)},
            "R6 captured words", res, {pat(t_rd + CL + 1, seed), pat(t_rd + CL, seed)});
        chk(t_done == t_rd + REC, "R7 done timing", t_done, t_rd + REC);
        @(negedge clk);
        chk(busy_o == 1'b0 && done_o == 1'b0, "R7 busy falls after done", {busy_o, done_o}, 0);
        chk(cmd_o == 2'd0, "R9 idle NOP", cmd_o, 0);
        chk(result_o == res, "R6 result holds", result_o, res);
        if (hold) begin
            chk(ack_o == 1'b1, "R2 ack one cycle after done", ack_o, 1);
            req_i = 1'b0;
            @(negedge clk);
            chk(busy_o == 1'b0, "R2 dropped request not taken", busy_o, 0);
        end
        traffic_idle_i = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            nerr++; nchk++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(cmd_o == 2'd0 && busy_o == 1'b0 && done_o == 1'b0 && result_o == '0,
            "R8 reset state", {cmd_o, busy_o, done_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy_o == 1'b0 && cmd_o == 2'd0, "R9 idle without request", {busy_o, cmd_o}, 0);
        for (int i = 0; i < 4; i++)
            run_seq(VEC[i][31], int'(VEC[i][30:24]), int'(VEC[i][23:16]), VEC[i][15:0], 1'b0);
        // Directed: request held across the done cycle
        run_seq(1'b1, 2, 0, 16'h5A5A, 1'b1);
        // Directed: long drain with banks closed
        run_seq(1'b0, 12, 5, 16'hC001, 1'b0);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule